// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is a small Moore state machine for a dispenser that charges fifteen cents. It accepts only nickels and dimes and never returns change. Each coin arrives as a one-cycle pulse from a coin detector. The machine keeps the credit inserted so far in a two-bit state register. When the credit reaches fifteen cents or more, it raises the release output. It holds the release output high, whatever coins follow, until a reset.

The credit values 0, 5, 10 and 15 cents are held as state codes 00, 01, 10 and 11. The release output is the AND of the two state bits. The coin detector is expected to deliver at most one coin per clock. If a nickel and a dime do arrive in the same cycle, the next state is whatever the next-state equations give. From 0 or 10 cents that is 15 cents, and from 5 cents it is 10 cents. The bench does not depend on this case.

Top module: `coin_credit_fsm`

## Requirements
- R1: Reset is synchronous and active-high. On the clock edge where `rst` is high, the credit returns to 0 cents and `release_o` is low one cycle later, even if a coin pulse is present in that same cycle.
- R2: In a cycle with no coin pulse, the credit is kept unchanged.
- R3: A nickel pulse adds 5 cents. Three nickels from 0 cents reach 15 cents, and two nickels do not.
- R4: A dime pulse adds 10 cents. A dime from 0 cents leaves `release_o` low, and a following nickel raises it.
- R5: A dime taken at 5 or 10 cents moves the credit to 15 cents. The extra 5 cents is absorbed and no further state exists.
- R6: `release_o` is a Moore output. It is high only in the 15-cent state (code 11) and first rises in the cycle after the edge that samples the completing coin.
- R7: In the 15-cent state the machine stays put on every input combination until a reset, so `release_o` remains high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to 0 cents |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was detected |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was detected |
| release_o | output | 1 | High while the credit is 15 cents or more |

## Verification
The stimulus table runs five coin orders: nickel-nickel-nickel, nickel-dime, dime-nickel, dime-dime and dime-nickel-nickel. Each run starts from a reset. The runs separate the case where the total lands exactly on 15 cents from the cases that overpay. Each one checks that the release does not come one coin early. Idle cycles placed between nickels show that credit is held rather than lost or counted twice. Coins and idle cycles sent after the release, together with a reset asserted alongside a dime, show that the release saturates and that reset takes priority.

// File: rtl/coin_credit_fsm.sv
module coin_credit_fsm (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic release_o
);
  typedef enum logic [1:0] {
    CR_0  = 2'b00,
    CR_5  = 2'b01,
    CR_10 = 2'b10,
    CR_15 = 2'b11
  } credit_t;

  credit_t state;
  logic    nxt_hi, nxt_lo;

  assign nxt_hi = state[1] | dime_i | (state[0] & nickel_i);
  assign nxt_lo = (~state[0] & nickel_i) | (state[0] & ~nickel_i)
                | (state[1] & nickel_i)  | (state[1] & dime_i);

  always_ff @(posedge clk) begin
    if (rst) state <= CR_0;
    else     state <= credit_t'({nxt_hi, nxt_lo});
  end

  assign release_o = state[1] & state[0];
endmodule

module coin_credit_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       nickel_i,
  input logic       dime_i,
  input logic       release_o,
  input logic [1:0] state
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (state == 2'b00) && !release_o);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(state));

  assert_nickel_step_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00 && nickel_i && !dime_i) |=> (state == 2'b01));

  assert_dime_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00 && dime_i && !nickel_i) |=> (state == 2'b10) && !release_o);

  assert_dime_saturates_R5: assert property (@(posedge clk) disable iff (rst)
    (state != 2'b00 && dime_i && !nickel_i) |=> release_o);

  assert_release_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    release_o |=> release_o);
endmodule

bind coin_credit_fsm coin_credit_fsm_chk u_chk (
  .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i),
  .release_o(release_o), .state(state)
);

// File: tb/coin_credit_fsm_tb.sv
module coin_credit_fsm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic release_o;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  coin_credit_fsm u_dut (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i),
    .release_o(release_o)
  );

  // entry: {req[3:0], rst, nickel, dime, expected release after the edge}
  localparam int NV = 32;
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'h1_8,                          // R1 reset
    8'h3_4, 8'h3_4, 8'h3_5,          // R3 N-N-N: third nickel releases
    8'h7_1, 8'h7_1,                  // R7 idle after release
    8'h1_8,
    8'h4_4, 8'h5_3,                  // R5 N-D
    8'h1_8,
    8'h4_2, 8'h4_5,                  // R4 D-N
    8'h1_8,
    8'h4_2, 8'h5_3, 8'h7_5, 8'h7_3,  // R5 D-D, then R7 more coins
    8'h1_8,
    8'h4_2, 8'h6_5, 8'h7_5,          // R6 D-N-N
    8'h1_8,
    8'h3_4, 8'h2_0, 8'h2_0,          // R2 idle keeps 5 cents
    8'h3_4, 8'h2_0, 8'h3_5,          // R3 third nickel after idles
    8'h1_a, 8'h1_0,                  // R1 reset with dime present
    8'h6_4, 8'h6_0                   // R6 one nickel alone: no release
  };

  task automatic step(input logic r, input logic n, input logic d,
                      input logic exp, input int req);
    @(negedge clk);
    rst = r; nickel_i = n; dime_i = d;
    @(posedge clk);
    #1;
    checks++;
    if (release_o !== exp) begin
      errors++;
      $display("FAIL R%0d: release_o=%b expected %b (rst=%b n=%b d=%b)",
               req, release_o, exp, r, n, d);
    end
  endtask

  initial begin
    step(1, 0, 0, 0, 1); // R1 state after reset
    for (int i = 0; i < NV; i++)
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], int'(VEC[i][7:4]));

    // R1: reset priority at 10 cents with a dime, then a nickel leaves 5 cents
    step(1, 0, 0, 0, 1);
    step(0, 0, 1, 0, 4);
    step(1, 0, 1, 0, 1);
    step(0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 2);

    // R6: release rises exactly on the edge after the completing nickel
    step(0, 1, 0, 0, 6);
    step(0, 1, 0, 1, 6);

    // R7: every input combination in the 15-cent state keeps release high
    for (int k = 0; k < 8; k++)
      step(0, k[0], k[1], 1, 7);

    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 2); // R2 idle at 0 cents stays low

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule